// File: doc/BRIEF.md
# OUT Endpoint Receive-Bank Handshake Controller

This block holds the receive status of one USB device endpoint and decides how each OUT data packet from the host is answered. The endpoint has one or two receive data banks. In single-bank operation every packet lands in bank 0. In dual-bank (ping-pong) operation packets alternate between the two banks. Each bank has a "full" flag. The packet engine sets that flag when a packet has been stored completely, and firmware clears it once the data has been read out. While a bank is full it refuses new data with a NAK. The exception is an isochronous endpoint, which always accepts.

The controller also drives a level interrupt while any full flag is set and interrupts are enabled. It keeps a firmware-written direction bit for control endpoints, and this bit selects the direction of the status stage. Firmware reads every flag through an 8-bit status byte and updates them through one write strobe. Serial line coding, CRC checking and the data FIFO live elsewhere. The packet engine only sends a request strobe for each OUT packet and a store-done strobe with the bank index.

Top module: `usb_out_bank_ctl`

## Requirements
- R1: After reset the status byte reads 0x00, `irq` is low, both reply strobes are low and the first dual-bank packet is aimed at bank 0.
- R2: In single-bank operation an `out_req` pulse in cycle t gives, in cycle t+1, exactly one of `reply_ack` or `reply_nak` with `reply_bank` = 0. The answer is NAK when the bank-0 full flag (status bit 1) was set in cycle t and the endpoint kind is not isochronous; otherwise it is ACK. With no request, both strobes are low and `reply_bank` is 0.
- R3: Dual-bank operation is in force only when `dual_en` is high and the parameter `EP_NUM` is 1 or 2. In that mode a store-done into bank b makes the other bank the preferred target of the next packet.
- R4: In dual-bank operation the target is the preferred bank unless that bank is full and the other one is empty, in which case the other bank is chosen. A non-isochronous request gets NAK only when the chosen bank is full.
- R5: A store-done sets the full flag of `store_bank` in dual-bank operation and the bank-0 flag otherwise. The bank-1 flag (status bit 6) is never set outside dual-bank operation.
- R6: With `ep_kind` = 1 (isochronous) every OUT request is answered with ACK, whatever the flags hold.
- R7: `irq` equals `irq_en` AND (bank-0 flag OR bank-1 flag). It stays high until firmware has cleared every set flag.
- R8: A write with a 0 in bit 1 or bit 6 clears that flag, and a 1 there leaves it unchanged. A store-done in the same cycle as a clearing write leaves the flag set.
- R9: Bits 7, 5 and 4 of the status byte hold the values last written to them. Bits 3, 2 and 0 always read 0.
- R10: `ctl_status_in` is high only when `ep_kind` = 0 (control) and the direction bit (status bit 7) is 0. A clear bit means a control write, whose status stage goes IN. A set bit means a control read, whose status stage goes OUT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_kind | input | 2 | Endpoint kind: 0 control, 1 isochronous, 2 bulk, 3 interrupt |
| dual_en | input | 1 | Request dual-bank (ping-pong) operation |
| irq_en | input | 1 | Endpoint interrupt enable |
| out_req | input | 1 | One-cycle strobe: an OUT data packet needs a reply |
| store_done | input | 1 | One-cycle strobe: a packet finished storing |
| store_bank | input | 1 | Bank the finished packet was stored in |
| reg_wr | input | 1 | Firmware write strobe for the status byte |
| reg_wdata | input | 8 | Firmware write data |
| reply_ack | output | 1 | Accept the requested packet (one cycle after `out_req`) |
| reply_nak | output | 1 | Refuse the requested packet (one cycle after `out_req`) |
| reply_bank | output | 1 | Bank the packet is to be stored in |
| status | output | 8 | Status byte: 7 direction, 6 bank-1 full, 5 stall request, 4 transmit ready, 1 bank-0 full |
| irq | output | 1 | Endpoint interrupt |
| ctl_status_in | output | 1 | Control status stage runs in the IN direction |

## Verification
The handshake is first tried in single-bank operation with an empty bank and then a full one, which separates the NAK rule from plain acceptance. A dual-bank sequence follows. It fills bank 0, then bank 1, then both, and clears each bank alone, so the preferred-bank order can be told apart from the empty-bank fallback and from the both-full NAK. The same full states are then replayed with the isochronous kind to show the exemption. Other patterns cover a clearing write that coincides with a store-done, writes of all-ones against set flags, and bank-1 stores while ping-pong is off; together they separate hardware setting from firmware clearing.

// File: rtl/usb_outbank_pkg.sv
package usb_outbank_pkg;

  typedef enum logic [1:0] {
    EPK_CTRL = 2'd0,
    EPK_ISO  = 2'd1,
    EPK_BULK = 2'd2,
    EPK_INTR = 2'd3
  } ep_kind_e;

  // Status byte bit positions (firmware decodes these)
  localparam int unsigned SB_DIR   = 7;
  localparam int unsigned SB_FULL1 = 6;
  localparam int unsigned SB_STALL = 5;
  localparam int unsigned SB_TXRDY = 4;
  localparam int unsigned SB_FULL0 = 1;

  // Chosen bank for the next OUT packet
  function automatic logic pick_bank(input logic pref, input logic [1:0] full,
                                     input logic dual);
    logic alt;
    alt = ~pref;
    if (!dual) return 1'b0;
    if (full[pref] && !full[alt]) return alt;
    return pref;
  endfunction

  // Accept unless the chosen bank is full, isochronous always accepts
  function automatic logic may_accept(input logic bank_full, input logic iso);
    return iso || !bank_full;
  endfunction

endpackage

// File: rtl/outbank_flags.sv
module outbank_flags #(
  parameter int unsigned NBANK = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBANK-1:0] set_vec,
  input  logic [NBANK-1:0] keep_vec,
  output logic [NBANK-1:0] full
);
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) full[b] <= 1'b0;
      else        full[b] <= (full[b] & keep_vec[b]) | set_vec[b];
    end
  end
endmodule

// File: rtl/outbank_steer.sv
module outbank_steer
  import usb_outbank_pkg::*;
#(
  parameter int unsigned NBANK = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dual,
  input  logic             iso,
  input  logic             out_req,
  input  logic             store_done,
  input  logic             store_bank,
  input  logic [NBANK-1:0] full,
  output logic [NBANK-1:0] set_vec,
  output logic             reply_ack,
  output logic             reply_nak,
  output logic             reply_bank
);
  logic pref_q;
  logic tgt;
  logic ok;
  logic eff_bank;

  always_comb begin
    tgt      = pick_bank(pref_q, full[1:0], dual);
    ok       = may_accept(full[tgt], iso);
    eff_bank = dual ? store_bank : 1'b0;
    set_vec  = '0;
    if (store_done) set_vec[eff_bank] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pref_q     <= 1'b0;
      reply_ack  <= 1'b0;
      reply_nak  <= 1'b0;
      reply_bank <= 1'b0;
    end else begin
      reply_ack  <= out_req && ok;
      reply_nak  <= out_req && !ok;
      reply_bank <= out_req ? tgt : 1'b0;
      if (store_done) pref_q <= dual ? ~store_bank : 1'b0;
    end
  end
endmodule

// File: rtl/outbank_ctlreg.sv
module outbank_ctlreg (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic dir_d,
  input  logic stall_d,
  input  logic txrdy_d,
  output logic dir_q,
  output logic stall_q,
  output logic txrdy_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= 1'b0;
      stall_q <= 1'b0;
      txrdy_q <= 1'b0;
    end else if (wr) begin
      dir_q   <= dir_d;
      stall_q <= stall_d;
      txrdy_q <= txrdy_d;
    end
  end
endmodule

// File: rtl/usb_out_bank_ctl.sv
module usb_out_bank_ctl
  import usb_outbank_pkg::*;
#(
  parameter int unsigned EP_NUM = 1,
  parameter int unsigned STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        ep_kind,
  input  logic              dual_en,
  input  logic              irq_en,
  input  logic              out_req,
  input  logic              store_done,
  input  logic              store_bank,
  input  logic              reg_wr,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic              reply_ack,
  output logic              reply_nak,
  output logic              reply_bank,
  output logic [STAT_W-1:0] status,
  output logic              irq,
  output logic              ctl_status_in
);
  localparam int unsigned NBANK   = 2;
  localparam bit          DUAL_OK = (EP_NUM == 1) || (EP_NUM == 2);

  ep_kind_e         kind;
  logic             dual_live;
  logic             is_iso;
  logic [NBANK-1:0] full;
  logic [NBANK-1:0] set_vec;
  logic [NBANK-1:0] keep_vec;
  logic             dir_q, stall_q, txrdy_q;
  logic             unused_wbits;

  assign kind         = ep_kind_e'(ep_kind);
  assign dual_live    = DUAL_OK && dual_en;
  assign is_iso       = (kind == EPK_ISO);
  assign keep_vec[0]  = !reg_wr || reg_wdata[SB_FULL0];
  assign keep_vec[1]  = !reg_wr || reg_wdata[SB_FULL1];
  assign unused_wbits = ^{reg_wdata[3:2], reg_wdata[0]};

  outbank_steer #(.NBANK(NBANK)) u_steer (
    .clk(clk), .rst_n(rst_n), .dual(dual_live), .iso(is_iso),
    .out_req(out_req), .store_done(store_done), .store_bank(store_bank),
    .full(full), .set_vec(set_vec), .reply_ack(reply_ack),
    .reply_nak(reply_nak), .reply_bank(reply_bank)
  );

  outbank_flags #(.NBANK(NBANK)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .keep_vec(keep_vec),
    .full(full)
  );

  outbank_ctlreg u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr),
    .dir_d(reg_wdata[SB_DIR]), .stall_d(reg_wdata[SB_STALL]),
    .txrdy_d(reg_wdata[SB_TXRDY]),
    .dir_q(dir_q), .stall_q(stall_q), .txrdy_q(txrdy_q)
  );

  always_comb begin
    status           = '0;
    status[SB_DIR]   = dir_q;
    status[SB_FULL1] = full[1];
    status[SB_STALL] = stall_q;
    status[SB_TXRDY] = txrdy_q;
    status[SB_FULL0] = full[0];
  end

  assign irq           = irq_en && (|full);
  assign ctl_status_in = (kind == EPK_CTRL) && !dir_q;
endmodule

// File: rtl/usb_out_bank_ctl_chk.sv
module usb_out_bank_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] ep_kind,
  input logic       dual_live,
  input logic       irq_en,
  input logic       out_req,
  input logic       store_done,
  input logic       reg_wr,
  input logic [7:0] status,
  input logic       reply_ack,
  input logic       reply_nak,
  input logic       irq
);
  // R2: every request is answered in the next cycle
  p_reply_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_req |=> (reply_ack || reply_nak));
  // R2: no reply without a request
  p_no_spurious_reply_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_req |=> !(reply_ack || reply_nak));
  // R6: isochronous requests are never refused
  p_iso_no_nak_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && ep_kind == 2'd1) |=> !reply_nak);
  // R4: both banks full on a non-isochronous dual endpoint refuses
  p_both_full_nak_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_req && dual_live && ep_kind != 2'd1 && status[6] && status[1])
      |=> reply_nak);
  // R5: bank-1 flag cannot appear outside dual-bank operation
  p_bank1_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual_live && !status[6]) |=> !status[6]);
  // R8: a firmware write alone never sets a flag
  p_write_no_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !store_done && !status[1]) |=> !status[1]);
  // R7: a newly set flag raises the interrupt when enabled
  p_irq_on_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(status[1]) && irq_en) |-> irq);
endmodule

bind usb_out_bank_ctl usb_out_bank_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ep_kind(ep_kind), .dual_live(dual_live),
  .irq_en(irq_en), .out_req(out_req), .store_done(store_done),
  .reg_wr(reg_wr), .status(status), .reply_ack(reply_ack),
  .reply_nak(reply_nak), .irq(irq)
);

// File: tb/usb_out_bank_ctl_test.sv
`timescale 1ns/1ps
module usb_out_bank_ctl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ep_kind = 2'd2;
  logic dual_en = 1'b0, irq_en = 1'b0, out_req = 1'b0;
  logic store_done = 1'b0, store_bank = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic reply_ack, reply_nak, reply_bank, irq, ctl_status_in;
  logic [7:0] status;

  int total = 0, fails = 0;

  always #4 clk = ~clk;

  usb_out_bank_ctl uut (
    .clk(clk), .rst_n(rst_n), .ep_kind(ep_kind), .dual_en(dual_en),
    .irq_en(irq_en), .out_req(out_req), .store_done(store_done),
    .store_bank(store_bank), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reply_ack(reply_ack), .reply_nak(reply_nak), .reply_bank(reply_bank),
    .status(status), .irq(irq), .ctl_status_in(ctl_status_in)
  );

  // Behavioural reference model (EP_NUM default is 1, so ping-pong allowed)
  int f0 = 0, f1 = 0, pref = 0, dir = 0, stl = 0, txr = 0;
  int e_ack = 0, e_nak = 0, e_bank = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      f0 = 0; f1 = 0; pref = 0; dir = 0; stl = 0; txr = 0;
      e_ack = 0; e_nak = 0; e_bank = 0;
    end else begin
      int dual, t, tf, nf0, nf1;
      dual = dual_en;
      e_ack = 0; e_nak = 0; e_bank = 0;
      if (out_req) begin
        if (!dual) t = 0;
        else begin
          t = pref;
          if (((t == 0) ? f0 : f1) != 0 && ((t == 0) ? f1 : f0) == 0) t = 1 - t;
        end
        tf = (t == 0) ? f0 : f1;
        if (ep_kind == 2'd1 || tf == 0) e_ack = 1; else e_nak = 1;
        e_bank = t;
      end
      nf0 = f0; nf1 = f1;
      if (reg_wr) begin
        if (!reg_wdata[1]) nf0 = 0;
        if (!reg_wdata[6]) nf1 = 0;
        dir = reg_wdata[7]; stl = reg_wdata[5]; txr = reg_wdata[4];
      end
      if (store_done) begin
        if (dual && store_bank) nf1 = 1; else nf0 = 1;
        pref = dual ? 1 - int'(store_bank) : 0;
      end
      f0 = nf0; f1 = nf1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic [7:0] es;
      es = {dir[0], f1[0], stl[0], txr[0], 2'b00, f0[0], 1'b0};
      check(status == es, "R5/R8/R9 status", status, es);
      check({reply_ack, reply_nak, reply_bank} ==
            {e_ack[0], e_nak[0], e_bank[0]}, "R2/R3/R4/R6 reply",
            {reply_ack, reply_nak, reply_bank}, {e_ack[0], e_nak[0], e_bank[0]});
      check(irq == (irq_en && (f0 != 0 || f1 != 0)), "R7 irq", irq,
            irq_en && (f0 != 0 || f1 != 0));
      check(ctl_status_in == (ep_kind == 2'd0 && dir == 0), "R10 ctl_status_in",
            ctl_status_in, ep_kind == 2'd0 && dir == 0);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask
  task automatic req();
    out_req = 1'b1; tick(); out_req = 1'b0;
  endtask
  task automatic store(input logic b);
    store_done = 1'b1; store_bank = b; tick(); store_done = 1'b0;
  endtask
  task automatic wr(input logic [7:0] d);
    reg_wr = 1'b1; reg_wdata = d; tick(); reg_wr = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1;
    check(status == 8'h00 && !irq && !reply_ack && !reply_nak, "R1 reset",
          {irq, reply_ack, reply_nak, status}, 0);
    tick(); tick(); rst_n = 1'b1; tick();
    check(status == 8'h00 && !irq, "R1 after reset release", status, 0);

    // Single bank, bulk
    irq_en = 1'b1;
    req();
    check(reply_ack && !reply_nak && !reply_bank, "R2 empty bank ack",
          {reply_ack, reply_nak, reply_bank}, 3'b100);
    store(1'b0);
    check(status == 8'h02 && irq, "R7 bank0 full irq", {irq, status}, 9'h102);
    req();
    check(reply_nak && !reply_ack, "R2 full bank nak", {reply_ack, reply_nak}, 2'b01);
    store(1'b1);
    check(status[6] == 1'b0, "R5 no bank1 when single", status, 8'h02);
    wr(8'h42);
    check(status == 8'h02, "R8 write one keeps flag", status, 8'h02);
    wr(8'h00);
    check(status == 8'h00 && !irq, "R8 write zero clears", {irq, status}, 0);

    // Dual bank
    dual_en = 1'b1;
    store(1'b1); wr(8'h00);   // set preference back to bank 0
    req();
    check(reply_ack && reply_bank == 1'b0, "R3 dual starts bank0",
          {reply_ack, reply_bank}, 2'b10);
    store(1'b0);
    req();
    check(reply_ack && reply_bank == 1'b1, "R3 alternate to bank1",
          {reply_ack, reply_bank}, 2'b11);
    store(1'b1);
    check(status == 8'h42, "R5 dual both flags", status, 8'h42);
    req();
    check(reply_nak, "R4 both full nak", {reply_ack, reply_nak}, 2'b01);
    ep_kind = 2'd1;
    req();
    check(reply_ack && !reply_nak, "R6 iso accepts when full",
          {reply_ack, reply_nak}, 2'b10);
    ep_kind = 2'd2;
    wr(8'h02);                 // clear bank1, preferred bank0 still full
    req();
    check(reply_ack && reply_bank == 1'b1, "R4 fallback to empty bank",
          {reply_ack, reply_bank}, 2'b11);
    irq_en = 1'b0; tick();
    check(!irq, "R7 irq gated by enable", irq, 0);
    irq_en = 1'b1;

    // Same-cycle store and clearing write
    reg_wr = 1'b1; reg_wdata = 8'h00; store_done = 1'b1; store_bank = 1'b1;
    tick(); reg_wr = 1'b0; store_done = 1'b0;
    check(status == 8'h40, "R8 store wins over clear", status, 8'h40);
    wr(8'h3D);
    check(status == 8'h30, "R9 plain bits and zero bits", status, 8'h30);

    // Direction bit
    ep_kind = 2'd0; wr(8'h80); #1;
    check(!ctl_status_in, "R10 control read status OUT", ctl_status_in, 0);
    wr(8'h00); #1;
    check(ctl_status_in, "R10 control write status IN", ctl_status_in, 1);
    ep_kind = 2'd3; #1;
    check(!ctl_status_in, "R10 non-control gives 0", ctl_status_in, 0);
    tick(); tick();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule